// File: doc/BRIEF.md
# Key-Locked NAND Strobe Timing Generator

This block sits between a register-programmed host and a raw 8-bit NAND device. It holds the interface configuration and a packed timing word. From these it produces the device strobes: command-latch enable, address-latch enable, write enable, read enable and chip enable. A host can ask for three kinds of cycle: a command byte write, an address byte write, or a raw data read. Each strobe phase lasts one more clock cycle than the value of its own timing field. A zero field therefore still gives a one-cycle phase.

Configuration is protected by a key. A write to one of the three protected registers takes effect only if the write just before it, to the lock register, carried the key 0x0000A25E. Any write to a protected register uses up the unlock, whether or not it was accepted. After a program-confirm or erase-confirm command byte, the block waits through a fixed busy window in which the device ready/busy line is ignored. It then waits for the line to go high. After a read, the block holds a bus turnaround gap before it takes another request.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset, `ready` is 1, `nandWeN` and `nandReN` are 1, `nandCle`, `nandAle`, `nandDqOe` and `rdValid` are 0, `cfgLargePage`, `cfgAddr4` and `ceOnDemand` are 0, `nandCeN` is 0, and `timingCfg` is all ones.
- R2: Register addresses are 0 for lock, 1 for interface control, 2 for chip enable and 3 for timing. A write to address 1, 2 or 3 is accepted only if the most recent register write was a lock write carrying exactly 0x0000A25E. A lock write with any other value locks the block.
- R3: Every write to address 1, 2 or 3 locks the block again, whether or not it was accepted. A second protected write therefore needs a fresh key.
- R4: The timing word holds these fields: write-low in bits 3:0, write-high in bits 7:4, read-low in bits 11:8, read-high in bits 15:12, turnaround in bits 18:16, busy delay in bits 23:19 and chip-enable access in bits 25:24. These bits appear on `timingCfg`. In the interface-control word, bit 2 drives `cfgLargePage` and bit 1 drives `cfgAddr4`. In the chip-enable word, bit 0 drives `ceOnDemand`.
- R5: When `byteReq` is seen in the idle state, a write cycle starts. `nandCle` is high if `byteIsAddr`=0, and `nandAle` is high if `byteIsAddr`=1. `nandWeN` stays low for write-low+1 cycles and then high for write-high+1 cycles. The latch strobe and `nandDqOe` stay high through both phases, and `nandDqOut` carries the byte throughout.
- R6: When `rdReq` is seen in the idle state, `nandReN` goes low for read-low+1 cycles. `dqIn` is captured at the edge that ends the low phase. `rdValid` pulses for one cycle, the first cycle after `nandReN` rises, with the byte on `rdData`.
- R7: After a read, `nandReN` stays high for read-high+1 cycles. A turnaround gap of turnaround+1 idle cycles follows, and `ready` stays low through it.
- R8: With `ceOnDemand`=1, each cycle begins with a chip-enable access phase of access+1 cycles in which only `nandCeN` is low. `nandCeN` is low only during that phase and the strobe phases. With `ceOnDemand`=0 there is no access phase and `nandCeN` is always 0.
- R9: After a command byte (not an address byte) of value 0x10 or 0xD0, `ready` stays low for busy-delay+1 cycles whatever the state of `rbN`. It then stays low until `rbN` is seen high.
- R10: `ready` is high exactly when the block is idle. Requests made while `ready` is low are ignored. If `byteReq` and `rdReq` come together, only the write is performed.
- R11: `nandWeN` and `nandReN` are never low together, and `nandCle` and `nandAle` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 lock, 1 interface control, 2 chip enable, 3 timing |
| regWrData | input | 32 | Register write data |
| byteReq | input | 1 | Request a command or address byte write |
| byteIsAddr | input | 1 | 1 = address byte, 0 = command byte |
| byteData | input | 8 | Byte to write |
| rdReq | input | 1 | Request a raw data read |
| rbN | input | 1 | Device ready/busy, high = ready |
| dqIn | input | 8 | Data bus from the device |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Write enable, active low |
| nandReN | output | 1 | Read enable, active low |
| nandCeN | output | 1 | Chip enable, active low |
| nandDqOut | output | 8 | Data bus to the device |
| nandDqOe | output | 1 | Output enable for the data bus |
| rdData | output | 8 | Byte captured by the last read |
| rdValid | output | 1 | One-cycle pulse when rdData is new |
| ready | output | 1 | Idle and able to accept a request |
| cfgLargePage | output | 1 | Large-page device selected |
| cfgAddr4 | output | 1 | Four address bytes selected |
| ceOnDemand | output | 1 | Chip enable driven only during cycles |
| timingCfg | output | 26 | Current timing word |

## Verification
The bench sweeps every phase field across small values and counts the cycles of each strobe phase. An off-by-one phase counter would show up as a phase one cycle short or one cycle long, and a zero field that skipped its phase would show up as a phase of zero cycles. Read capture is checked against a data bus that changes on every cycle of the low phase, so capturing one cycle early or late returns a different byte. The key lock is tested with a missing key, a wrong key and a reused key; a lock that did not re-arm would let the second write change `timingCfg`. The busy window is tested with ready/busy held high throughout, released late, and with an address byte of the same value as a confirm command; a design that sampled ready/busy too early would return to ready too soon, and one that ignored the command/address distinction would stall after the address byte.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int CNT_W   = 5;
  localparam int TIM_W   = 26;
  localparam int WRL_LSB = 0;
  localparam int WRH_LSB = 4;
  localparam int RDL_LSB = 8;
  localparam int RDH_LSB = 12;
  localparam int TA_LSB  = 16;
  localparam int BSY_LSB = 19;
  localparam int CEA_LSB = 24;
  localparam int NIB_W   = 4;
  localparam int TA_W    = 3;
  localparam int BSY_W   = 5;
  localparam int CEA_W   = 2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CEA, ST_WLOW, ST_WHIGH, ST_RLOW, ST_RHIGH, ST_TA, ST_BDLY, ST_BWAIT
  } stateT;

  typedef enum logic [2:0] {
    FLD_WLOW, FLD_WHIGH, FLD_RLOW, FLD_RHIGH, FLD_TA, FLD_BUSY, FLD_CEA
  } fieldSelT;

  typedef struct packed {
    logic     loadCnt;
    fieldSelT fieldSel;
    logic     latchByte;
    logic     captureRd;
  } ctrlStrobeT;

endpackage

// File: rtl/nand_strobe_dp.sv
module nand_strobe_dp
  import nand_strobe_pkg::*;
#(
  parameter int          DQ_W      = 8,
  parameter int          REG_W     = 32,
  parameter logic [31:0] LOCK_KEY  = 32'h0000_A25E,
  parameter logic [7:0]  PROG_CMD  = 8'h10,
  parameter logic [7:0]  ERASE_CMD = 8'hD0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [DQ_W-1:0]  byteData,
  input  logic [DQ_W-1:0]  dqIn,
  input  ctrlStrobeT       ctrl,
  output logic             cntZero,
  output logic             busyCmd,
  output logic [DQ_W-1:0]  latchedByte,
  output logic [DQ_W-1:0]  rdData,
  output logic             rdValid,
  output logic             cfgLargePage,
  output logic             cfgAddr4,
  output logic             ceOnDemand,
  output logic [TIM_W-1:0] timingCfg
);

  localparam logic [1:0] ADDR_LOCK = 2'd0;
  localparam logic [1:0] ADDR_ICR  = 2'd1;
  localparam logic [1:0] ADDR_CE   = 2'd2;
  localparam logic [1:0] ADDR_TIM  = 2'd3;

  logic             unlocked;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] fieldVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unlocked     <= 1'b0;
      cfgLargePage <= 1'b0;
      cfgAddr4     <= 1'b0;
      ceOnDemand   <= 1'b0;
      timingCfg    <= '1;
    end else if (regWe) begin
      if (regAddr == ADDR_LOCK) begin
        unlocked <= (regWrData == REG_W'(LOCK_KEY));
      end else begin
        unlocked <= 1'b0;
        if (unlocked) begin
          case (regAddr)
            ADDR_ICR: begin
              cfgLargePage <= regWrData[2];
              cfgAddr4     <= regWrData[1];
            end
            ADDR_CE:  ceOnDemand <= regWrData[0];
            ADDR_TIM: timingCfg  <= regWrData[TIM_W-1:0];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    case (ctrl.fieldSel)
      FLD_WLOW:  fieldVal = CNT_W'(timingCfg[WRL_LSB +: NIB_W]);
      FLD_WHIGH: fieldVal = CNT_W'(timingCfg[WRH_LSB +: NIB_W]);
      FLD_RLOW:  fieldVal = CNT_W'(timingCfg[RDL_LSB +: NIB_W]);
      FLD_RHIGH: fieldVal = CNT_W'(timingCfg[RDH_LSB +: NIB_W]);
      FLD_TA:    fieldVal = CNT_W'(timingCfg[TA_LSB +: TA_W]);
      FLD_BUSY:  fieldVal = CNT_W'(timingCfg[BSY_LSB +: BSY_W]);
      FLD_CEA:   fieldVal = CNT_W'(timingCfg[CEA_LSB +: CEA_W]);
      default:   fieldVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt         <= '0;
      latchedByte <= '0;
      rdData      <= '0;
      rdValid     <= 1'b0;
    end else begin
      if (ctrl.loadCnt)   cnt <= fieldVal;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      if (ctrl.latchByte) latchedByte <= byteData;
      if (ctrl.captureRd) rdData <= dqIn;
      rdValid <= ctrl.captureRd;
    end
  end

  assign cntZero = (cnt == '0);
  assign busyCmd = (latchedByte == DQ_W'(PROG_CMD)) || (latchedByte == DQ_W'(ERASE_CMD));

endmodule

// File: rtl/nand_strobe_ctl.sv
module nand_strobe_ctl
  import nand_strobe_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       byteReq,
  input  logic       byteIsAddr,
  input  logic       rdReq,
  input  logic       rbN,
  input  logic       cntZero,
  input  logic       busyCmd,
  input  logic       ceOnDemand,
  output ctrlStrobeT ctrl,
  output logic       nandCle,
  output logic       nandAle,
  output logic       nandWeN,
  output logic       nandReN,
  output logic       nandCeN,
  output logic       nandDqOe,
  output logic       ready
);

  stateT state, nxt;
  logic  isAddr, opRead;

  always_comb begin
    nxt            = state;
    ctrl.loadCnt   = 1'b0;
    ctrl.fieldSel  = FLD_WLOW;
    ctrl.latchByte = 1'b0;
    ctrl.captureRd = 1'b0;
    case (state)
      ST_IDLE: begin
        if (byteReq) begin
          ctrl.latchByte = 1'b1;
          ctrl.loadCnt   = 1'b1;
          if (ceOnDemand) begin nxt = ST_CEA;  ctrl.fieldSel = FLD_CEA;  end
          else            begin nxt = ST_WLOW; ctrl.fieldSel = FLD_WLOW; end
        end else if (rdReq) begin
          ctrl.loadCnt = 1'b1;
          if (ceOnDemand) begin nxt = ST_CEA;  ctrl.fieldSel = FLD_CEA;  end
          else            begin nxt = ST_RLOW; ctrl.fieldSel = FLD_RLOW; end
        end
      end
      ST_CEA: if (cntZero) begin
        ctrl.loadCnt = 1'b1;
        if (opRead) begin nxt = ST_RLOW; ctrl.fieldSel = FLD_RLOW; end
        else        begin nxt = ST_WLOW; ctrl.fieldSel = FLD_WLOW; end
      end
      ST_WLOW: if (cntZero) begin
        nxt = ST_WHIGH; ctrl.loadCnt = 1'b1; ctrl.fieldSel = FLD_WHIGH;
      end
      ST_WHIGH: if (cntZero) begin
        if (!isAddr && busyCmd) begin
          nxt = ST_BDLY; ctrl.loadCnt = 1'b1; ctrl.fieldSel = FLD_BUSY;
        end else begin
          nxt = ST_IDLE;
        end
      end
      ST_RLOW: if (cntZero) begin
        nxt = ST_RHIGH; ctrl.loadCnt = 1'b1; ctrl.fieldSel = FLD_RHIGH;
        ctrl.captureRd = 1'b1;
      end
      ST_RHIGH: if (cntZero) begin
        nxt = ST_TA; ctrl.loadCnt = 1'b1; ctrl.fieldSel = FLD_TA;
      end
      ST_TA:    if (cntZero) nxt = ST_IDLE;
      ST_BDLY:  if (cntZero) nxt = rbN ? ST_IDLE : ST_BWAIT;
      ST_BWAIT: if (rbN) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      isAddr <= 1'b0;
      opRead <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && (byteReq || rdReq)) begin
        opRead <= !byteReq;
        isAddr <= byteIsAddr;
      end
    end
  end

  logic wrPhase, inCycle;
  assign wrPhase  = (state == ST_WLOW) || (state == ST_WHIGH);
  assign inCycle  = wrPhase || (state == ST_CEA) || (state == ST_RLOW) || (state == ST_RHIGH);
  assign nandWeN  = (state != ST_WLOW);
  assign nandReN  = (state != ST_RLOW);
  assign nandCle  = wrPhase && !isAddr;
  assign nandAle  = wrPhase && isAddr;
  assign nandDqOe = wrPhase;
  assign nandCeN  = ceOnDemand && !inCycle;
  assign ready    = (state == ST_IDLE);

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_strobe_pkg::*;
#(
  parameter int          DQ_W     = 8,
  parameter int          REG_W    = 32,
  parameter logic [31:0] LOCK_KEY = 32'h0000_A25E
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [1:0]       regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic             byteReq,
  input  logic             byteIsAddr,
  input  logic [DQ_W-1:0]  byteData,
  input  logic             rdReq,
  input  logic             rbN,
  input  logic [DQ_W-1:0]  dqIn,
  output logic             nandCle,
  output logic             nandAle,
  output logic             nandWeN,
  output logic             nandReN,
  output logic             nandCeN,
  output logic [DQ_W-1:0]  nandDqOut,
  output logic             nandDqOe,
  output logic [DQ_W-1:0]  rdData,
  output logic             rdValid,
  output logic             ready,
  output logic             cfgLargePage,
  output logic             cfgAddr4,
  output logic             ceOnDemand,
  output logic [TIM_W-1:0] timingCfg
);

  ctrlStrobeT ctrl;
  logic       cntZero, busyCmd;

  nand_strobe_dp #(.DQ_W(DQ_W), .REG_W(REG_W), .LOCK_KEY(LOCK_KEY)) u_dp (
    .clk, .rstN, .regWe, .regAddr, .regWrData, .byteData, .dqIn, .ctrl,
    .cntZero, .busyCmd, .latchedByte(nandDqOut), .rdData, .rdValid,
    .cfgLargePage, .cfgAddr4, .ceOnDemand, .timingCfg
  );

  nand_strobe_ctl u_ctl (
    .clk, .rstN, .byteReq, .byteIsAddr, .rdReq, .rbN, .cntZero, .busyCmd,
    .ceOnDemand, .ctrl, .nandCle, .nandAle, .nandWeN, .nandReN, .nandCeN,
    .nandDqOe, .ready
  );

endmodule

// File: rtl/nand_strobe_chk.sv
module nand_strobe_chk #(
  parameter int          REG_W    = 32,
  parameter logic [31:0] LOCK_KEY = 32'h0000_A25E
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWe,
  input logic [1:0]       regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic             nandCle,
  input logic             nandAle,
  input logic             nandWeN,
  input logic             nandReN,
  input logic             nandCeN,
  input logic             nandDqOe,
  input logic             rdValid,
  input logic             ready,
  input logic             ceOnDemand,
  input logic [25:0]      timingCfg
);

  logic keyArmed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      keyArmed <= 1'b0;
    else if (regWe) keyArmed <= (regAddr == 2'd0) && (regWrData == REG_W'(LOCK_KEY));
  end

  AST_LOCKED_TIMING_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd3 && !keyArmed) |=> $stable(timingCfg)); // R2
  AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN)); // R11
  AST_CLE_ALE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle)); // R11
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe)); // R10
  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid); // R6
  AST_CE_FORCED: assert property (@(posedge clk) disable iff (!rstN)
    !ceOnDemand |-> !nandCeN); // R8
  AST_WE_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> (nandCle || nandAle)); // R5

endmodule

bind nand_strobe_gen nand_strobe_chk #(.REG_W(REG_W), .LOCK_KEY(LOCK_KEY)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regWrData(regWrData),
  .nandCle(nandCle), .nandAle(nandAle), .nandWeN(nandWeN), .nandReN(nandReN),
  .nandCeN(nandCeN), .nandDqOe(nandDqOe), .rdValid(rdValid), .ready(ready),
  .ceOnDemand(ceOnDemand), .timingCfg(timingCfg)
);

// File: tb/nand_strobe_gen_bench.sv
`timescale 1ns/1ps
module nand_strobe_gen_bench;

  localparam logic [31:0] KEY = 32'h0000_A25E;

  logic clk = 1'b0, rstN = 1'b0;
  logic regWe = 1'b0, byteReq = 1'b0, byteIsAddr = 1'b0, rdReq = 1'b0, rbN = 1'b1;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [7:0]  byteData = '0, dqIn = '0;
  logic nandCle, nandAle, nandWeN, nandReN, nandCeN, nandDqOe, rdValid, ready;
  logic cfgLargePage, cfgAddr4, ceOnDemand;
  logic [7:0]  nandDqOut, rdData;
  logic [25:0] timingCfg;

  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  nand_strobe_gen u_nand_strobe_gen (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] packTim(int wl, int wh, int rl, int rh, int ta, int bd, int cea);
    return {6'd0, 2'(cea), 5'(bd), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
  endfunction

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    regWe = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic keyedWrite(input logic [1:0] a, input logic [31:0] d);
    regWrite(2'd0, KEY);
    regWrite(a, d);
  endtask

  // Runs one cycle and classifies every sampled cycle until ready returns.
  task automatic runOp(input bit isRead, input bit isAddr, input logic [7:0] b,
                       input bit bothReq, input bit midRd, input int releaseAt,
                       output int cea, output int wLow, output int wHigh, output int rLow,
                       output int post, output int postCe, output int rdvPos,
                       output logic [7:0] rdSeen, output bit busOk);
    bit seen = 0;
    int guard = 0;
    cea = 0; wLow = 0; wHigh = 0; rLow = 0; post = 0; postCe = 0; rdvPos = 0;
    rdSeen = '0; busOk = 1;
    byteData = b; byteIsAddr = isAddr;
    if (isRead) rdReq = 1'b1; else byteReq = 1'b1;
    if (bothReq) rdReq = 1'b1;
    @(negedge clk);
    byteReq = 1'b0; rdReq = 1'b0;
    while (!ready && guard < 400) begin
      guard++;
      rdReq = (midRd && guard == 1);
      if (!nandWeN) begin
        wLow++; seen = 1;
        if (nandDqOut !== b || !nandDqOe || nandCle !== !isAddr || nandAle !== isAddr) busOk = 0;
      end else if (!nandReN) begin
        rLow++; seen = 1;
        dqIn = 8'h40 + 8'(rLow);
      end else if (nandCle || nandAle) begin
        wHigh++;
        if (nandDqOut !== b || !nandDqOe) busOk = 0;
      end else if (!seen) begin
        cea++;
      end else begin
        post++;
        if (!nandCeN) postCe++;
        if (rdValid) begin rdvPos = post; rdSeen = rdData; end
        if (releaseAt != 0 && post == releaseAt) rbN = 1'b1;
      end
      @(negedge clk);
    end
    rdReq = 1'b0;
  endtask

  int cea, wLow, wHigh, rLow, post, postCe, rdvPos;
  logic [7:0] rdSeen;
  bit busOk;

  initial begin
    #(8 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ready && nandWeN && nandReN && !nandCle && !nandAle && !nandDqOe && !rdValid,
        "R1 idle strobes", int'(ready), 1);
    chk(!cfgLargePage && !cfgAddr4 && !ceOnDemand && !nandCeN, "R1 config", int'(ceOnDemand), 0);
    chk(timingCfg == 26'h3FF_FFFF, "R1 timing", int'(timingCfg), 26'h3FF_FFFF);

    // R2 write without key ignored
    regWrite(2'd3, packTim(1, 1, 1, 1, 1, 1, 1));
    chk(timingCfg == 26'h3FF_FFFF, "R2 no key", int'(timingCfg), 26'h3FF_FFFF);
    // R2 wrong key ignored
    regWrite(2'd0, 32'h0001_A25E);
    regWrite(2'd3, packTim(1, 1, 1, 1, 1, 1, 1));
    chk(timingCfg == 26'h3FF_FFFF, "R2 wrong key", int'(timingCfg), 26'h3FF_FFFF);
    // R2 good key then wrong key relocks
    regWrite(2'd0, KEY);
    regWrite(2'd0, 32'h0);
    regWrite(2'd1, 32'h6);
    chk(!cfgLargePage && !cfgAddr4, "R2 relock", int'(cfgLargePage), 0);
    // R4 field positions
    keyedWrite(2'd3, packTim(2, 3, 4, 5, 6, 7, 1));
    chk(timingCfg == packTim(2, 3, 4, 5, 6, 7, 1) && timingCfg[18:16] == 3'd6 && timingCfg[23:19] == 5'd7,
        "R4 timing", int'(timingCfg), int'(packTim(2, 3, 4, 5, 6, 7, 1)));
    // R3 second write without fresh key ignored
    regWrite(2'd3, packTim(0, 0, 0, 0, 0, 0, 0));
    chk(timingCfg == packTim(2, 3, 4, 5, 6, 7, 1), "R3 key consumed", int'(timingCfg),
        int'(packTim(2, 3, 4, 5, 6, 7, 1)));
    // R3 rejected write also consumes key
    regWrite(2'd0, KEY);
    regWrite(2'd1, 32'h4);
    regWrite(2'd2, 32'h1);
    chk(cfgLargePage && !cfgAddr4 && !ceOnDemand, "R3 one write per key", int'(ceOnDemand), 0);
    keyedWrite(2'd1, 32'h2);
    chk(!cfgLargePage && cfgAddr4, "R4 icr bits", int'(cfgAddr4), 1);

    // R5 write sweep, CE forced
    for (int wl = 0; wl < 4; wl++)
      for (int wh = 0; wh < 4; wh++)
        for (int k = 0; k < 2; k++) begin
          keyedWrite(2'd3, packTim(wl, wh, 0, 0, 0, 0, 0));
          runOp(0, k[0], 8'(8'hA0 + wl * 4 + wh), 0, 0, 0,
                cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
          chk(wLow == wl + 1, "R5 we low width", wLow, wl + 1);
          chk(wHigh == wh + 1, "R5 we high width", wHigh, wh + 1);
          chk(busOk && cea == 0 && post == 0 && rLow == 0, "R5 latch and bus", int'(busOk), 1);
        end

    // R6 R7 read sweep, CE forced
    for (int rl = 0; rl < 4; rl++)
      for (int rh = 0; rh < 3; rh++)
        for (int ta = 0; ta < 3; ta++) begin
          keyedWrite(2'd3, packTim(0, 0, rl, rh, ta, 0, 0));
          runOp(1, 0, 8'h00, 0, 0, 0,
                cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
          chk(rLow == rl + 1, "R6 re low width", rLow, rl + 1);
          chk(rdvPos == 1 && rdSeen == 8'(8'h40 + rl + 1), "R6 capture", int'(rdSeen), 8'h40 + rl + 1);
          chk(post == rh + ta + 2 && wLow == 0, "R7 high plus turnaround", post, rh + ta + 2);
        end

    // R8 CE on demand
    keyedWrite(2'd2, 32'h1);
    chk(ceOnDemand && nandCeN, "R8 ce idle high", int'(nandCeN), 1);
    for (int c = 0; c < 4; c++) begin
      keyedWrite(2'd3, packTim(1, 2, 2, 1, 2, 0, c));
      runOp(0, 1, 8'h5A, 0, 0, 0, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
      chk(cea == c + 1 && wLow == 2 && wHigh == 3, "R8 write access phase", cea, c + 1);
      runOp(1, 0, 8'h00, 0, 0, 0, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
      chk(cea == c + 1 && rLow == 3, "R8 read access phase", cea, c + 1);
      chk(postCe == 2 && post == 5, "R8 ce released in turnaround", postCe, 2);
    end
    keyedWrite(2'd2, 32'h0);

    // R9 busy handling
    for (int bd = 0; bd < 6; bd += 2) begin
      keyedWrite(2'd3, packTim(0, 0, 0, 0, 0, bd, 0));
      rbN = 1'b1;
      runOp(0, 0, 8'h10, 0, 0, 0, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
      chk(post == bd + 1, "R9 busy delay rb high", post, bd + 1);
      rbN = 1'b0;
      runOp(0, 0, 8'hD0, 0, 0, bd + 4, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
      chk(post == bd + 4, "R9 wait for rb", post, bd + 4);
      rbN = 1'b0;
      runOp(0, 1, 8'h10, 0, 0, 0, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
      chk(post == 0, "R9 address byte no busy", post, 0);
      rbN = 1'b1;
    end

    // R10 arbitration and ignored requests
    keyedWrite(2'd3, packTim(3, 1, 0, 0, 0, 0, 0));
    runOp(0, 0, 8'h33, 1, 0, 0, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
    chk(rLow == 0 && wLow == 4, "R10 byte wins", rLow, 0);
    runOp(0, 0, 8'h34, 0, 1, 0, cea, wLow, wHigh, rLow, post, postCe, rdvPos, rdSeen, busOk);
    chk(rLow == 0 && wLow == 4 && wHigh == 2, "R10 busy request ignored", rLow, 0);
    chk(ready && nandReN, "R10 ready after cycle", int'(ready), 1);
    @(negedge clk);
    chk(nandReN && ready, "R10 no late read", int'(nandReN), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule